// File: doc/BRIEF.md
# Carry-Select Adder with Early Carry Selection

This block adds two unsigned operands of a configurable width and a single carry-in bit, producing a sum of the same width and a carry-out. It is purely combinational and holds no state, so a result is available in the same cycle as its operands.

A single first stage computes, for each bit, the operand XOR (the half-sum) and the operand AND (the half-carry). Two carry chains share those words. One chain computes every carry on the assumption that the carry-in is 0, and the other on the assumption that it is 1.

The chosen carry word is picked before any sum bit is formed. A carry produced with carry-in 0 is always also produced with carry-in 1, so each bit of the pick is a single AND-OR term instead of a 2:1 multiplexer. The final stage XORs the chosen carries, shifted up by one position, with the half-sum. Every XOR in the block is written as an OR masked by a NAND.

Top module: `csel_adder`

## Requirements
- R1: For every operand pair and carry-in, the concatenation {co, s} equals a + b + ci, computed at WIDTH+1 bits.
- R2: Bit 0 of s equals a[0] XOR b[0] XOR ci.
- R3: With ci = 0, {co, s} equals a + b. In particular, with b = 0 and ci = 0, s equals a and co is 0.
- R4: With ci = 1, {co, s} equals a + b + 1. In particular, a all ones, b = 0 and ci = 1 gives s = 0 and co = 1, a carry that propagates through every position.
- R5: co is 1 exactly when a + b + ci is at least 2^WIDTH.
- R6: For the same a and b, a carry-out of 1 with ci = 0 implies a carry-out of 1 with ci = 1. Internally, every bit set in the carry-in-0 word is also set in the carry-in-1 word.
- R7: The WIDTH parameter defaults to 16. The adder gives correct results at 64 bits as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| ci | input | 1 | Carry into bit 0 |
| s | output | WIDTH | Sum |
| co | output | 1 | Carry out of the top bit |

## Verification
Random operand pairs at 16 and 64 bits, with a random carry-in, exercise the two carry chains and the AND-OR pick across mixed propagate and generate runs. Directed patterns target specific faults:
- All-ones plus zero with carry-in 1 exposes a broken ripple through the carry-in-1 chain that random data seldom reaches.
- Zero operands and pure-generate words (all ones plus all ones) separate seeding errors in the two chains.
- Repeating one operand pair under both carry-in values shows whether the selection term uses the right chain, and whether the chains keep their required ordering.

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  output logic [WIDTH-1:0] s,
  output logic             co
);
  localparam int MSB = WIDTH - 1;

  logic [MSB:0] hs, hc, k0, k1, csel;

  assign k0[0] = hc[0];
  assign k1[0] = hc[0] | hs[0];
  assign s[0]  = (hs[0] | ci) & ~(hs[0] & ci);

  genvar i;
  generate
    for (i = 0; i <= MSB; i++) begin : g_bit
      assign hs[i]   = (a[i] | b[i]) & ~(a[i] & b[i]);
      assign hc[i]   = a[i] & b[i];
      assign csel[i] = k0[i] | (ci & k1[i]);
      if (i > 0) begin : g_up
        assign k0[i] = hc[i] | (hs[i] & k0[i-1]);
        assign k1[i] = hc[i] | (hs[i] & k1[i-1]);
        assign s[i]  = (hs[i] | csel[i-1]) & ~(hs[i] & csel[i-1]);
      end
    end
  endgenerate

  assign co = csel[MSB];
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             ci,
  input logic [WIDTH-1:0] s,
  input logic             co,
  input logic [WIDTH-1:0] k0,
  input logic [WIDTH-1:0] k1
);
  logic [WIDTH:0] tot;
  assign tot = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci};

  always_comb begin
    a_r1_sum_matches: assert ({co, s} == tot)
      else $error("R1 sum mismatch");
    a_r2_lsb_parity: assert (s[0] == (a[0] ^ b[0] ^ ci))
      else $error("R2 lsb mismatch");
    a_r3_zero_addend: assert (!(b == '0 && !ci) || (s == a && !co))
      else $error("R3 identity mismatch");
    a_r5_carry_out: assert (co == tot[WIDTH])
      else $error("R5 carry-out mismatch");
    a_r6_chain_order: assert ((k0 & ~k1) == '0)
      else $error("R6 chain order violated");
  end
endmodule

bind csel_adder csel_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a(a), .b(b), .ci(ci), .s(s), .co(co), .k0(k0), .k1(k1)
);

// File: tb/csel_adder_bench.sv
module csel_adder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] a, b;
  logic        ci;
  logic [15:0] s16;
  logic        co16;
  logic [63:0] s64;
  logic        co64;
  int checks = 0;
  int fails  = 0;

  csel_adder u_csel_adder (
    .a(a[15:0]), .b(b[15:0]), .ci(ci), .s(s16), .co(co16)
  );
  csel_adder #(.WIDTH(64)) u_csel_adder_w64 (
    .a(a), .b(b), .ci(ci), .s(s64), .co(co64)
  );

  function automatic logic [16:0] ref16(logic [15:0] x, logic [15:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {16'd0, c};
  endfunction

  function automatic logic [64:0] ref64(logic [63:0] x, logic [63:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {64'd0, c};
  endfunction

  task automatic chk(string req, logic [64:0] got, logic [64:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(logic [63:0] x, logic [63:0] y, logic c);
    @(posedge clk);
    a = x; b = y; ci = c;
    @(negedge clk);
  endtask

  task automatic check_both(string req);
    chk({req, " w16"}, {48'd0, co16, s16}, {48'd0, ref16(a[15:0], b[15:0], ci)});
    chk({req, " R7 w64"}, {co64, s64}, ref64(a, b, ci));
    chk("R2 lsb", {64'd0, s16[0]}, {64'd0, a[0] ^ b[0] ^ ci});
    chk("R5 cout", {64'd0, co16}, {64'd0, ref16(a[15:0], b[15:0], ci) >= 17'h10000});
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic c0, c1;
    a = '0; b = '0; ci = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle zero", {48'd0, co16, s16}, 65'd0);

    apply('1, 64'd0, 1'b1);
    check_both("R4 full ripple");
    chk("R4 w16 all ones", {48'd0, co16, s16}, {48'd0, 17'h10000});
    chk("R4 w64 all ones", {co64, s64}, {1'b1, 64'd0});

    apply(64'h1234_5678_9abc_def0, 64'd0, 1'b0);
    check_both("R3 zero addend");
    chk("R3 identity", {1'b0, s64}, {1'b0, a});

    apply('1, '1, 1'b0);
    check_both("R3 all generate");
    apply('1, '1, 1'b1);
    check_both("R4 all generate");
    apply(64'h5555_5555_5555_5555, 64'haaaa_aaaa_aaaa_aaaa, 1'b0);
    check_both("R3 all propagate");

    for (int n = 0; n < 3000; n++) begin
      apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
      check_both("R1 random");
    end

    for (int n = 0; n < 300; n++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom};
      y = ~x ^ (64'd1 << ($urandom % 64));
      apply(x, y, 1'b0);
      c0 = co64;
      check_both("R3 near ripple");
      apply(x, y, 1'b1);
      c1 = co64;
      check_both("R4 near ripple");
      chk("R6 chain order", {64'd0, c0 & ~c1}, 65'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule